// File: doc/BRIEF.md
# Burst SPI Master with Coded Clock Divider

This block is an SPI master for 8-bit words. A byte-wide configuration register sets the clock polarity, the clock phase, the bit order and the serial clock rate. The rate comes from a 2-bit code that picks one of four fixed fractions of the system clock. A burst is requested with a byte count. The block then asserts chip-select and exchanges the bytes one at a time with an external buffer. For each byte it reads the outgoing value through a fetch strobe and an index, and writes the incoming value back through a store strobe at the same index. When the last byte has been shifted, it releases chip-select and pulses a completion flag.

The configuration can be written at any time. A burst uses the value the register held when the burst was accepted, and a write made during a burst only affects later bursts. Between bursts the serial clock rests at the level that the polarity bit of the current register value selects.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the configuration is 0x00, which gives mode 0, MSB first and a clock period of 4 system clocks. After reset csN is 1, sclk is 0, done is 0 and busy is 0.
- R2: While csN is high, sclk equals bit 3 (polarity) of the configuration register, and it changes only after a configuration write.
- R3: Bit 2 of the configuration selects the phase. With phase 0, each bit is on mosi before the first edge and is sampled on the leading edge. With phase 1, each bit is driven on the leading edge and sampled on the trailing edge. All four polarity/phase combinations exchange bytes correctly in both directions.
- R4: Bit 5 of the configuration set means each byte is shifted LSB first on mosi and assembled LSB first from miso. Clear means MSB first.
- R5: Bits 1:0 of the configuration set the sclk period to 4, 16, 64 or 128 system clocks for codes 00, 01, 10 and 11, so one sclk level lasts 2, 8, 32 or 64 clocks.
- R6: A start pulse in an idle cycle with byteCount N > 0 holds csN low for the whole burst and produces exactly 16·N sclk edges. Each byte k is read through fetchReq with bufIdx = k, and its received value is given on storeData with storeValid and bufIdx = k.
- R7: done is high for exactly one cycle per burst. That cycle is the first cycle with csN high after the burst.
- R8: A configuration write during a burst changes neither the mode, the bit order nor the rate of that burst. The next burst uses the new value.
- R9: A start pulse with byteCount 0, or a start pulse during a burst, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 8 | Configuration value: [1:0] rate code, [2] phase, [3] polarity, [5] LSB first |
| start | input | 1 | Burst request |
| byteCount | input | CNT_W | Number of bytes in the burst |
| fetchReq | output | 1 | Outgoing byte at bufIdx is read in this cycle |
| bufIdx | output | CNT_W | Buffer index of the current byte |
| fetchData | input | 8 | Outgoing byte, valid while fetchReq is high |
| storeValid | output | 1 | Received byte for bufIdx is on storeData |
| storeData | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip-select |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
A behavioural slave model follows the programmed polarity, phase and bit order. The same byte stream runs through all four modes and through both bit orders. A wrong sampling edge or a reversed shift direction then shows up as corrupted bytes in at least one direction. Every rate code is run, and the cycle gap between the first two sclk edges is measured. This catches a wrong code-to-divisor mapping. Configuration writes made during a burst, and extra start pulses, are compared against the unchanged burst timing and the store count. Together they show that the latched state is isolated from the live register.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W   = 8;
  localparam int HALF_W   = 6;
  localparam int EDGE_W   = $clog2(2 * WORD_W + 1);
  localparam int CPHA_BIT = 2;
  localparam int CPOL_BIT = 3;
  localparam int LSB_BIT  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_PREP, ST_SHIFT, ST_STORE, ST_TAIL, ST_DONE
  } burstState_t;

  typedef struct packed {
    logic load;
    logic drive;
    logic sample;
  } dpStrobe_t;

  function automatic logic [HALF_W-1:0] halfLimit(input logic [1:0] code);
    case (code)
      2'b00:   halfLimit = HALF_W'(1);
      2'b01:   halfLimit = HALF_W'(7);
      2'b10:   halfLimit = HALF_W'(31);
      default: halfLimit = HALF_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [WORD_W-1:0]    cfgData,
  input  logic                 start,
  input  logic [CNT_W-1:0]     byteCount,
  output dpStrobe_t            strobe,
  output logic                 lsbFirst,
  output logic                 sclk,
  output logic                 csN,
  output logic                 busy,
  output logic                 done,
  output logic                 fetchReq,
  output logic                 storeValid,
  output logic [CNT_W-1:0]     bufIdx
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_W - 1);

  burstState_t       state;
  logic [WORD_W-1:0] cfgReg;
  logic [WORD_W-1:0] actCfg;
  logic [WORD_W-1:0] effCfg;
  logic [CNT_W-1:0]  bytesLeft;
  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W-1:0] limit;
  logic [EDGE_W-1:0] edgeCnt;
  logic              sclkPhase;
  logic              cpha;
  logic              edgeNow;
  logic              leadingNow;
  logic              lastEdge;
  logic              accept;

  assign csN        = (state == ST_IDLE) || (state == ST_DONE);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign fetchReq   = (state == ST_LOAD);
  assign storeValid = (state == ST_STORE);

  assign effCfg     = csN ? cfgReg : actCfg;
  assign cpha       = effCfg[CPHA_BIT];
  assign lsbFirst   = effCfg[LSB_BIT];
  assign limit      = halfLimit(effCfg[1:0]);
  assign sclk       = effCfg[CPOL_BIT] ^ sclkPhase;

  assign accept     = (state == ST_IDLE) && start && (byteCount != '0);
  assign edgeNow    = (state == ST_SHIFT) && (halfCnt == limit);
  assign leadingNow = ~edgeCnt[0];
  assign lastEdge   = (edgeCnt == LAST_EDGE);

  always_comb begin
    strobe.load   = (state == ST_LOAD);
    strobe.drive  = ((state == ST_PREP) && !cpha) ||
                    (edgeNow && (cpha ? leadingNow : (!leadingNow && !lastEdge)));
    strobe.sample = edgeNow && (cpha ? !leadingNow : leadingNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cfgReg    <= '0;
      actCfg    <= '0;
      bytesLeft <= '0;
      bufIdx    <= '0;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else begin
      if (cfgWe) cfgReg <= cfgData;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            actCfg    <= cfgReg;
            bytesLeft <= byteCount;
            bufIdx    <= '0;
            state     <= ST_LOAD;
          end
        end
        ST_LOAD: state <= ST_PREP;
        ST_PREP: begin
          halfCnt <= '0;
          edgeCnt <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (halfCnt == limit) begin
            halfCnt   <= '0;
            sclkPhase <= ~sclkPhase;
            edgeCnt   <= edgeCnt + 1'b1;
            if (lastEdge) state <= ST_STORE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_STORE: begin
          bytesLeft <= bytesLeft - 1'b1;
          if (bytesLeft == CNT_W'(1)) begin
            halfCnt <= '0;
            state   <= ST_TAIL;
          end else begin
            bufIdx <= bufIdx + 1'b1;
            state  <= ST_LOAD;
          end
        end
        ST_TAIL: begin
          if (halfCnt == limit) state <= ST_DONE;
          else halfCnt <= halfCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_dp.sv
module spi_burst_dp
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              lsbFirst,
  input  logic [WORD_W-1:0] fetchData,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxData
);
  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] rxReg;
  logic              mosiReg;
  logic              txHead;
  logic [WORD_W-1:0] txNext;
  logic [WORD_W-1:0] rxNext;

  always_comb begin
    if (lsbFirst) begin
      txHead = txReg[0];
      txNext = {1'b0, txReg[WORD_W-1:1]};
      rxNext = {miso, rxReg[WORD_W-1:1]};
    end else begin
      txHead = txReg[WORD_W-1];
      txNext = {txReg[WORD_W-2:0], 1'b0};
      rxNext = {rxReg[WORD_W-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg   <= '0;
      rxReg   <= '0;
      mosiReg <= 1'b0;
    end else begin
      if (strobe.load) begin
        txReg <= fetchData;
      end else if (strobe.drive) begin
        mosiReg <= txHead;
        txReg   <= txNext;
      end
      if (strobe.sample) rxReg <= rxNext;
    end
  end

  assign mosi   = mosiReg;
  assign rxData = rxReg;
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgData,
  input  logic              start,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              fetchReq,
  output logic [CNT_W-1:0]  bufIdx,
  input  logic [7:0]        fetchData,
  output logic              storeValid,
  output logic [7:0]        storeData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN,
  output logic              busy,
  output logic              done
);
  dpStrobe_t strobe;
  logic      lsbFirst;

  spi_burst_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgData    (cfgData),
    .start      (start),
    .byteCount  (byteCount),
    .strobe     (strobe),
    .lsbFirst   (lsbFirst),
    .sclk       (sclk),
    .csN        (csN),
    .busy       (busy),
    .done       (done),
    .fetchReq   (fetchReq),
    .storeValid (storeValid),
    .bufIdx     (bufIdx)
  );

  spi_burst_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lsbFirst  (lsbFirst),
    .fetchData (fetchData),
    .miso      (miso),
    .mosi      (mosi),
    .rxData    (storeData)
  );
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic             start,
  input logic [CNT_W-1:0] byteCount,
  input logic             fetchReq,
  input logic             storeValid,
  input logic             sclk,
  input logic             csN,
  input logic             busy,
  input logic             done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !$past(csN)));  // R7
  AST_FETCH_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> !csN);  // R6
  AST_STORE_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    storeValid |-> !csN);  // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (byteCount != '0)) |=> !csN);  // R6
  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && !$past(cfgWe)) |-> $stable(sclk));  // R2
endmodule

bind spi_burst_master spi_burst_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWe      (cfgWe),
  .start      (start),
  .byteCount  (byteCount),
  .fetchReq   (fetchReq),
  .storeValid (storeValid),
  .sclk       (sclk),
  .csN        (csN),
  .busy       (busy),
  .done       (done)
);

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [7:0]       cfgData = '0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic             fetchReq;
  logic [CNT_W-1:0] bufIdx;
  logic [7:0]       fetchData;
  logic             storeValid;
  logic [7:0]       storeData;
  logic             sclk;
  logic             mosi;
  logic             miso = 1'b0;
  logic             csN;
  logic             busy;
  logic             done;

  logic [7:0] mTx [0:15];
  logic [7:0] mRx [0:15];
  logic [7:0] sTx [0:15];
  logic [7:0] sRx [0:15];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int donePulses = 0;
  int doneCsBad = 0;
  int storeCnt = 0;
  int csLowCycles = 0;
  int edgeN = 0;
  int edgeT0 = 0;
  int edgeT1 = 0;

  bit sCpol = 0, sCpha = 0, sLsb = 0;
  int sIdx = 0, sBit = 0;
  logic [7:0] sSh = '0, sIn = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_burst_master #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .start(start), .byteCount(byteCount), .fetchReq(fetchReq),
    .bufIdx(bufIdx), .fetchData(fetchData), .storeValid(storeValid),
    .storeData(storeData), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN), .busy(busy), .done(done)
  );

  assign fetchData = mTx[bufIdx[3:0]];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done) begin
      donePulses = donePulses + 1;
      if (!csN) doneCsBad = doneCsBad + 1;
    end
    if (storeValid) begin
      mRx[bufIdx[3:0]] = storeData;
      storeCnt = storeCnt + 1;
    end
    if (!csN) csLowCycles = csLowCycles + 1;
  end

  // behavioural slave
  task automatic slvDrive();
    miso = sLsb ? sSh[0] : sSh[7];
    sSh  = sLsb ? (sSh >> 1) : (sSh << 1);
  endtask

  task automatic slvSample();
    sIn  = sLsb ? {mosi, sIn[7:1]} : {sIn[6:0], mosi};
    sBit = sBit + 1;
    if (sBit == 8) begin
      sRx[sIdx[3:0]] = sIn;
      sIdx = sIdx + 1;
      sBit = 0;
      sSh  = sTx[sIdx[3:0]];
    end
  endtask

  always @(negedge csN) begin
    sIdx = 0;
    sBit = 0;
    sSh  = sTx[0];
    if (!sCpha) slvDrive();
  end

  always @(sclk) begin
    if (!csN) begin
      if (edgeN == 0) edgeT0 = cyc;
      if (edgeN == 1) edgeT1 = cyc;
      edgeN = edgeN + 1;
      if (sclk != sCpol) begin
        if (sCpha) slvDrive(); else slvSample();
      end else begin
        if (sCpha) slvSample(); else slvDrive();
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgData = v;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  function automatic int halfOf(input logic [7:0] c);
    case (c[1:0])
      2'b00: halfOf = 2;
      2'b01: halfOf = 8;
      2'b10: halfOf = 32;
      default: halfOf = 64;
    endcase
  endfunction

  // midAct: 0 none, 1 configuration write of midVal, 2 extra start pulse
  task automatic runBurst(input logic [7:0] burstCfg, input int n, input string tag,
                          input int midAct, input logic [7:0] midVal, input int seed);
    int waitCnt;
    sCpol = burstCfg[3]; sCpha = burstCfg[2]; sLsb = burstCfg[5];
    for (int i = 0; i < 16; i++) begin
      mTx[i] = 8'(seed * 29 + i * 53 + 8'h1B);
      sTx[i] = 8'(seed * 71 + i * 37 + 8'hC4);
      mRx[i] = 8'h00;
      sRx[i] = 8'h00;
    end
    donePulses = 0; doneCsBad = 0; storeCnt = 0; edgeN = 0;
    @(posedge clk); #1;
    start = 1'b1; byteCount = CNT_W'(n);
    @(posedge clk); #1;
    start = 1'b0; byteCount = '0;
    if (midAct != 0) begin
      repeat (12) @(posedge clk);
      #1;
      if (midAct == 1) begin
        cfgWe = 1'b1; cfgData = midVal;
      end else begin
        start = 1'b1; byteCount = CNT_W'(5);
      end
      @(posedge clk); #1;
      cfgWe = 1'b0; start = 1'b0; byteCount = '0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt = waitCnt + 1;
    end
    repeat (3) @(negedge clk);
    check(waitCnt < 20000, {tag, " R6 burst completes"}, waitCnt, 0);
    for (int i = 0; i < n; i++) begin
      check(mRx[i] == sTx[i], {tag, " R3 master received byte"}, int'(mRx[i]), int'(sTx[i]));
      check(sRx[i] == mTx[i], {tag, " R4 slave received byte"}, int'(sRx[i]), int'(mTx[i]));
    end
    check(storeCnt == n, {tag, " R6 store count"}, storeCnt, n);
    check(edgeN == 16 * n, {tag, " R6 sclk edge count"}, edgeN, 16 * n);
    check(donePulses == 1 && doneCsBad == 0, {tag, " R7 single done with csN high"},
          donePulses * 16 + doneCsBad, 16);
    check(edgeT1 - edgeT0 == halfOf(burstCfg), {tag, " R5 half period"},
          edgeT1 - edgeT0, halfOf(burstCfg));
  endtask

  task automatic testReset();
    @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0 && done == 1'b0 && busy == 1'b0,
          "R1 reset outputs", {csN, sclk, done, busy}, 4'b1000);
    runBurst(8'h00, 3, "R1 default mode0 msb div4", 0, 8'h00, 1);
  endtask

  task automatic testModes();
    writeCfg(8'h04); runBurst(8'h04, 3, "R3 mode1", 0, 8'h00, 2);
    writeCfg(8'h08); runBurst(8'h08, 3, "R3 mode2", 0, 8'h00, 3);
    @(negedge clk);
    check(sclk == 1'b1, "R2 idle high after mode2", sclk, 1);
    writeCfg(8'h0C); runBurst(8'h0C, 2, "R3 mode3", 0, 8'h00, 4);
  endtask

  task automatic testOrder();
    writeCfg(8'h20); runBurst(8'h20, 2, "R4 lsb mode0", 0, 8'h00, 5);
    writeCfg(8'h2C); runBurst(8'h2C, 2, "R4 lsb mode3", 0, 8'h00, 6);
  endtask

  task automatic testDivisors();
    writeCfg(8'h01); runBurst(8'h01, 2, "R5 div16", 0, 8'h00, 7);
    writeCfg(8'h06); runBurst(8'h06, 1, "R5 div64", 0, 8'h00, 8);
    writeCfg(8'h23); runBurst(8'h23, 1, "R5 div128", 0, 8'h00, 9);
  endtask

  task automatic testIdleLevel();
    writeCfg(8'h08);
    @(negedge clk);
    check(sclk == 1'b1, "R2 idle level follows polarity set", sclk, 1);
    writeCfg(8'h00);
    @(negedge clk);
    check(sclk == 1'b0, "R2 idle level follows polarity clear", sclk, 0);
  endtask

  task automatic testMidWrite();
    writeCfg(8'h00);
    runBurst(8'h00, 2, "R8 write during burst", 1, 8'h2B, 10);
    runBurst(8'h2B, 1, "R8 next burst uses new value", 0, 8'h00, 11);
  endtask

  task automatic testIgnored();
    writeCfg(8'h00);
    csLowCycles = 0;
    @(posedge clk); #1;
    start = 1'b1; byteCount = '0;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(csLowCycles == 0 && busy == 1'b0, "R9 zero count ignored", csLowCycles, 0);
    runBurst(8'h00, 2, "R9 start during burst ignored", 2, 8'h00, 12);
    repeat (10) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1, "R9 no second burst", {busy, csN}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mTx[i] = '0; mRx[i] = '0; sTx[i] = '0; sRx[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testModes();
    testOrder();
    testDivisors();
    testIdleLevel();
    testMidWrite();
    testIgnored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule